// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Shared Prescaler

This block is an eight-bit up-counter for a small processor. It can run in two ways. In timer mode it counts the processor's instruction-cycle enable. In counter mode it counts edges on an external clock pin, and software chooses whether rising or falling edges count. The external pin is brought into the clock domain through a two-stage synchronizer before its edges are detected.

One eight-bit prescaler counter serves one of two users, chosen by a control bit. It either divides the timer's input by a power of two, or it divides a watchdog's tick stream as a postscaler. It never serves both at once.

Software reaches the block over a small register bus with three registers: the count, the control word and the interrupt register. Writing the count loads the new value at once, clears the prescaler when the timer owns it, and holds counting off for two instruction cycles. When the count wraps from FFh to 00h, a sticky flag is set. The interrupt line is that flag qualified by two enables.

Top module: `tmr8_pscale`

## Requirements
- R1: After reset the count reads 00h, the control word reads FFh, the interrupt register reads 00h, and irq is low.
- R2: The bus decodes three registers: address 0 is the count, address 1 is the control word and address 2 is the interrupt register. Address 3 reads 00h. A write to any of them reads back, and a count write takes effect at the write's clock edge.
- R3: After a count write, the count keeps the written value through the next two clock edges on which cyc_en is high. The earliest increment is at the third such edge.
- R4: Control bit 5 selects the clock. When it is 0 (timer mode), each clock edge with cyc_en high is one input tick. When control bit 3 is 1, the timer counts those ticks at 1:1.
- R5: When control bit 3 is 0, the prescaler belongs to the timer. The count then advances once per 2^(code+1) input ticks, where the code is control bits 2..0. A count write clears the prescaler, so a control value of C3h gives 1:16.
- R6: When control bit 5 is 1 (counter mode), the timer counts edges of ext_clk_pin. Control bit 4 selects the edge: 0 for rising, 1 for falling. A pin change first affects the count at the third clock edge after it.
- R7: A wrap of the count from FFh to 00h sets interrupt-register bit 2 at that same edge. The bit stays set until software writes 0 to it.
- R8: irq is high exactly when interrupt-register bits 2, 5 and 7 are all 1.
- R9: When control bit 3 is 1, wdt_out pulses with every 2^code-th wdt_src pulse, where the code is control bits 2..0. A wdt_clr strobe clears the prescaler, and count writes leave it untouched.
- R10: When control bit 3 is 0, wdt_out follows wdt_src one-for-one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from bus_addr) |
| ext_clk_pin | input | 1 | External count pin (asynchronous) |
| wdt_src | input | 1 | Watchdog base tick |
| wdt_clr | input | 1 | Watchdog clear strobe |
| wdt_out | output | 1 | Watchdog tick after the postscaler |
| irq | output | 1 | Qualified overflow interrupt |

## Verification
- **Count writes:** the written value is visible after the write edge. With cyc_en held high, the first increment follows 2^(code+1) edges, pushed back to the first multiple at or beyond three edges. The bench predicts each value as floor(t/R) - floor(2/R), clamped at zero, and reads the count at every falling edge of the sweep.
- **External pin:** a pin change reaches the count at the third rising edge after it. The bench checks the count after the first, second and third edges. Pulses are held for four cycles, so that the settled totals are exact.
- **Overflow flag:** it is set at the same edge as the wrap. It is checked on the following falling edge.
- **Outputs:** wdt_out and irq are combinational. They are sampled a short delay after their inputs change, away from any clock edge.

// File: rtl/tps_pkg.sv
package tps_pkg;
   localparam int unsigned DW = 8;

   localparam logic [1:0] RA_COUNT = 2'd0;
   localparam logic [1:0] RA_CTRL  = 2'd1;
   localparam logic [1:0] RA_INTC  = 2'd2;

   // control word fields
   localparam int unsigned CB_CLKSEL = 5;   // 1: external pin
   localparam int unsigned CB_FALL   = 4;   // 1: falling edge
   localparam int unsigned CB_TO_WDT = 3;   // 1: prescaler serves watchdog

   // interrupt register fields
   localparam int unsigned IB_GLOBAL = 7;
   localparam int unsigned IB_TMR_EN = 5;
   localparam int unsigned IB_FLAG   = 2;

   localparam logic [DW-1:0] CTRL_RST = 8'hFF;

   typedef struct packed {
      logic glob_en;
      logic tmr_en;
      logic flag;
   } intc_t;
endpackage

// File: rtl/tps_edge_sync.sv
module tps_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic fall_sel_i,
   output logic edge_o
);
   localparam int unsigned CHAIN = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("tps_edge_sync: STAGES must be at least 2");
   end

   logic [CHAIN-1:0] sh_q;
   logic             s_new, s_old;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[CHAIN-2:0], pin_i};
   end

   assign s_new  = sh_q[STAGES-1];
   assign s_old  = sh_q[STAGES];
   assign edge_o = fall_sel_i ? (s_old & ~s_new) : (s_new & ~s_old);

   AST_SINGLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_o && $stable(fall_sel_i)) |=> !edge_o || !$stable(fall_sel_i)); // R6
endmodule

// File: rtl/tps_prescaler.sv
module tps_prescaler #(
   parameter int unsigned PS_W  = 8,
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             to_wdt_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             tmr_src_i,
   input  logic             cnt_wr_i,
   input  logic             wdt_src_i,
   input  logic             wdt_clr_i,
   output logic             tmr_tick_o,
   output logic             wdt_out_o
);
   if (PS_W < (1 << SEL_W)) begin : g_bad_width
      $error("tps_prescaler: PS_W too narrow for SEL_W codes");
   end

   logic [PS_W-1:0] psc_q, tmr_mask, wdt_mask;
   logic            src, clr, tmr_full, wdt_full;

   for (genvar i = 0; i < PS_W; i++) begin : g_mask
      assign tmr_mask[i] = (i <= int'(sel_i));
      assign wdt_mask[i] = (i <  int'(sel_i));
   end

   assign src = to_wdt_i ? wdt_src_i : tmr_src_i;
   assign clr = to_wdt_i ? wdt_clr_i : cnt_wr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   psc_q <= '0;
      else if (clr) psc_q <= '0;
      else if (src) psc_q <= psc_q + 1'b1;
   end

   assign tmr_full   = &(psc_q | ~tmr_mask);
   assign wdt_full   = &(psc_q | ~wdt_mask);
   assign tmr_tick_o = to_wdt_i ? tmr_src_i : (tmr_src_i & tmr_full);
   assign wdt_out_o  = to_wdt_i ? (wdt_src_i & wdt_full) : wdt_src_i;

   AST_PSC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> psc_q == '0); // R5
   AST_TICK_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_tick_o |-> tmr_src_i); // R5
   AST_WDT_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_out_o |-> wdt_src_i); // R9
endmodule

// File: rtl/tps_count.sv
module tps_count #(
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned HOLD_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_en_i,
   input  logic             tick_i,
   input  logic             wr_en_i,
   input  logic [CNT_W-1:0] wr_data_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o
);
   localparam int unsigned HW = (HOLD_CYC > 0) ? $clog2(HOLD_CYC + 1) : 1;

   if (CNT_W < 2) begin : g_bad_width
      $error("tps_count: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             held, adv;

   if (HOLD_CYC > 0) begin : g_hold
      logic [HW-1:0] hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      hold_q <= '0;
         else if (wr_en_i)                hold_q <= HW'(HOLD_CYC);
         else if (cyc_en_i && hold_q != '0) hold_q <= hold_q - 1'b1;
      end
      assign held = (hold_q != '0);
   end else begin : g_nohold
      assign held = 1'b0;
   end

   assign adv   = tick_i & ~wr_en_i & ~held;
   assign ovf_o = adv & (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (wr_en_i) cnt_q <= wr_data_i;
      else if (adv)     cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> cnt_q == $past(wr_data_i)); // R2
   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (held && !wr_en_i) |=> cnt_q == $past(cnt_q)); // R3
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R4
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> cnt_q == '0); // R7
endmodule

// File: rtl/tmr8_pscale.sv
module tmr8_pscale
   import tps_pkg::*;
#(
   parameter int unsigned PS_W        = 8,
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD_CYC    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cyc_en,
   input  logic          bus_we,
   input  logic [1:0]    bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          ext_clk_pin,
   input  logic          wdt_src,
   input  logic          wdt_clr,
   output logic          wdt_out,
   output logic          irq
);
   if (SEL_W < 1 || SEL_W > CB_TO_WDT) begin : g_bad_sel
      $error("tmr8_pscale: SEL_W must fit below the assignment bit");
   end

   logic [DW-1:0] ctrl_q, cnt;
   intc_t         intc_q;
   logic          wr_cnt, wr_ctrl, wr_intc;
   logic          ext_edge, tmr_src, tmr_tick, ovf;
   logic          unused_wbits;

   assign wr_cnt  = bus_we && (bus_addr == RA_COUNT);
   assign wr_ctrl = bus_we && (bus_addr == RA_CTRL);
   assign wr_intc = bus_we && (bus_addr == RA_INTC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= CTRL_RST;
      else if (wr_ctrl) ctrl_q <= bus_wdata;
   end

   tps_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (ext_clk_pin),
      .fall_sel_i (ctrl_q[CB_FALL]),
      .edge_o     (ext_edge)
   );

   assign tmr_src = ctrl_q[CB_CLKSEL] ? ext_edge : cyc_en;

   tps_prescaler #(.PS_W(PS_W), .SEL_W(SEL_W)) u_psc (
      .clk        (clk),
      .rst_n      (rst_n),
      .to_wdt_i   (ctrl_q[CB_TO_WDT]),
      .sel_i      (ctrl_q[SEL_W-1:0]),
      .tmr_src_i  (tmr_src),
      .cnt_wr_i   (wr_cnt),
      .wdt_src_i  (wdt_src),
      .wdt_clr_i  (wdt_clr),
      .tmr_tick_o (tmr_tick),
      .wdt_out_o  (wdt_out)
   );

   tps_count #(.CNT_W(DW), .HOLD_CYC(HOLD_CYC)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .cyc_en_i  (cyc_en),
      .tick_i    (tmr_tick),
      .wr_en_i   (wr_cnt),
      .wr_data_i (bus_wdata),
      .cnt_o     (cnt),
      .ovf_o     (ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         intc_q <= '0;
      end else begin
         if (wr_intc) begin
            intc_q.glob_en <= bus_wdata[IB_GLOBAL];
            intc_q.tmr_en  <= bus_wdata[IB_TMR_EN];
         end
         if (ovf)          intc_q.flag <= 1'b1;
         else if (wr_intc) intc_q.flag <= bus_wdata[IB_FLAG];
      end
   end

   assign unused_wbits = ^{bus_wdata[6], bus_wdata[4:3], bus_wdata[1:0]};

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         RA_COUNT: bus_rdata = cnt;
         RA_CTRL:  bus_rdata = ctrl_q;
         RA_INTC: begin
            bus_rdata[IB_GLOBAL] = intc_q.glob_en;
            bus_rdata[IB_TMR_EN] = intc_q.tmr_en;
            bus_rdata[IB_FLAG]   = intc_q.flag;
         end
         default: bus_rdata = '0;
      endcase
   end

   assign irq = intc_q.flag & intc_q.tmr_en & intc_q.glob_en;

   AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> intc_q.flag); // R7
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (intc_q.flag && !wr_intc) |=> intc_q.flag); // R7
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !wr_intc) |=> intc_q.flag); // R8
endmodule

// File: tb/sim_tmr8_pscale.sv
module sim_tmr8_pscale;
   logic       clk = 1'b0, rst_n = 1'b0, cyc_en = 1'b0, bus_we = 1'b0;
   logic       ext_pin = 1'b0, wdt_src = 1'b0, wdt_clr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   wire  [7:0] bus_rdata;
   wire        irq, wdt_out;
   int         total = 0, bad = 0;

   always #10 clk = ~clk;

   tmr8_pscale u0 (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ext_clk_pin(ext_pin), .wdt_src(wdt_src), .wdt_clr(wdt_clr),
      .wdt_out(wdt_out), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      bus_addr = a;
      #1;
      v = int'(bus_rdata);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   // count value after write edge + t, from write value 10h
   task automatic sweep(input logic [7:0] ctrl, input int ratio, input int tmax);
      int v;
      string tag;
      wr(2'd1, ctrl);
      wr(2'd0, 8'h10);
      for (int t = 0; t <= tmax; t++) begin
         int inc;
         inc = t / ratio - 2 / ratio;
         if (inc < 0) inc = 0;
         if (t < 3)           tag = "R3";
         else if (ratio == 1) tag = "R4";
         else                 tag = "R5";
         rd(2'd0, v);
         chk(tag, v, (16 + inc) & 255);
         @(negedge clk);
      end
   endtask

   task automatic pin_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         ext_pin = 1'b1;
         repeat (4) @(negedge clk);
         ext_pin = 1'b0;
         repeat (4) @(negedge clk);
      end
   endtask

   task automatic wpulse(output int o);
      wdt_src = 1'b1;
      #2;
      o = int'(wdt_out);
      @(negedge clk);
      wdt_src = 1'b0;
      @(negedge clk);
   endtask

   task automatic wclear();
      wdt_clr = 1'b1;
      @(negedge clk);
      wdt_clr = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int v, o;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, v); chk("R1", v, 8'h00);
      rd(2'd1, v); chk("R1", v, 8'hFF);
      rd(2'd2, v); chk("R1", v, 8'h00);
      chk("R1", int'(irq), 0);

      // R2 register map and readback
      wr(2'd1, 8'h5A); rd(2'd1, v); chk("R2", v, 8'h5A);
      wr(2'd0, 8'h77); rd(2'd0, v); chk("R2", v, 8'h77);
      rd(2'd3, v); chk("R2", v, 8'h00);

      // R5 prescaler sweep, codes 0..7 (C3h is 1:16), R3 first cycles
      cyc_en = 1'b1;
      for (int k = 0; k < 8; k++) begin
         int r;
         r = 2 << k;
         sweep(8'hC0 | 8'(k), r, 2 * r + 4);
      end
      // R4 timer mode, prescaler with watchdog -> 1:1
      sweep(8'h08, 1, 20);

      // R3 hold counts instruction-cycle enables, not clocks
      cyc_en = 1'b0;
      wr(2'd0, 8'h50);
      for (int i = 0; i < 4; i++) begin
         rd(2'd0, v); chk("R3", v, 8'h50);
         @(negedge clk);
      end
      cyc_en = 1'b1;
      @(negedge clk); rd(2'd0, v); chk("R3", v, 8'h50);
      @(negedge clk); rd(2'd0, v); chk("R3", v, 8'h50);
      @(negedge clk); rd(2'd0, v); chk("R3", v, 8'h51);

      // R7 R8 overflow
      wr(2'd2, 8'hA0);
      wr(2'd0, 8'hFE);
      repeat (4) @(negedge clk);
      rd(2'd0, v); chk("R7", v, 8'h00);
      rd(2'd2, v); chk("R7", v, 8'hA4);
      chk("R8", int'(irq), 1);
      wr(2'd1, 8'h28);                       // counter mode, pin idle
      repeat (3) @(negedge clk);
      rd(2'd2, v); chk("R7", v, 8'hA4);
      wr(2'd2, 8'h84); chk("R8", int'(irq), 0);
      wr(2'd2, 8'h24); chk("R8", int'(irq), 0);
      wr(2'd2, 8'hA4); chk("R8", int'(irq), 1);
      wr(2'd2, 8'hA0); rd(2'd2, v); chk("R7", v, 8'hA0);
      chk("R8", int'(irq), 0);

      // R6 counter mode, rising, with latency
      wr(2'd0, 8'h00);
      repeat (4) @(negedge clk);
      ext_pin = 1'b1;
      @(negedge clk); rd(2'd0, v); chk("R6", v, 0);
      @(negedge clk); rd(2'd0, v); chk("R6", v, 0);
      @(negedge clk); rd(2'd0, v); chk("R6", v, 1);
      ext_pin = 1'b0;
      repeat (4) @(negedge clk);
      pin_pulses(5);
      rd(2'd0, v); chk("R6", v, 6);

      // R6 falling edges
      wr(2'd1, 8'h38);
      wr(2'd0, 8'h00);
      repeat (4) @(negedge clk);
      ext_pin = 1'b1;
      repeat (5) @(negedge clk);
      rd(2'd0, v); chk("R6", v, 0);
      ext_pin = 1'b0;
      repeat (4) @(negedge clk);
      pin_pulses(4);
      rd(2'd0, v); chk("R6", v, 5);

      // R5 prescaler on external edges, code 1 -> 1:4
      wr(2'd1, 8'h21);
      wr(2'd0, 8'h00);
      repeat (4) @(negedge clk);
      pin_pulses(8);
      rd(2'd0, v); chk("R5", v, 2);

      // R9 watchdog postscaler, code 2 -> 1:4
      wr(2'd1, 8'h0A);
      wclear();
      for (int i = 1; i <= 12; i++) begin
         wpulse(o); chk("R9", o, (i % 4 == 0) ? 1 : 0);
      end
      wclear();
      wpulse(o); chk("R9", o, 0);
      wpulse(o); chk("R9", o, 0);
      wclear();
      for (int i = 1; i <= 4; i++) begin
         wpulse(o); chk("R9", o, (i == 4) ? 1 : 0);
      end
      wclear();
      wpulse(o); chk("R9", o, 0);
      wpulse(o); chk("R9", o, 0);
      wr(2'd0, 8'h33);
      wpulse(o); chk("R9", o, 0);
      wpulse(o); chk("R9", o, 1);

      // R10 prescaler with timer: watchdog tick passes 1:1
      wr(2'd1, 8'h02);
      for (int i = 0; i < 3; i++) begin
         wpulse(o); chk("R10", o, 1);
      end
      #2; chk("R10", int'(wdt_out), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule